// File: doc/BRIEF.md
# Bouncing bit-position staircase counter

This block produces the bit-position sequence that reads out one 8-bit codeword per sample period. A counter climbs one step per clock to its all-ones value, holds there for one clock, reloads one step below the top and descends to zero. It holds at zero for one clock, reloads at one and climbs again. Because the count reverses at each end, consecutive codewords are read out in opposite bit orders.

The low bits of the counter form the bit index. A direction flag tells the consumer which order the current word uses. A horizontal-control strobe of fixed length marks every turnaround, and a sync strobe fires when the counter passes one chosen value.

The sequencer is a four-state machine with the states RISE, TOP_HOLD, FALL and BOT_HOLD. Its transitions are:
- RISE→RISE, which counts up.
- RISE→TOP_HOLD, when the counter is at all ones.
- TOP_HOLD→FALL, which reloads all-ones minus one.
- FALL→FALL, which counts down.
- FALL→BOT_HOLD, when the counter is at zero.
- BOT_HOLD→RISE, which reloads one.

The reset values of the count and the state are parameters. From any of them the machine enters the same repeating cycle.

Top module: `bounce_stair_gen`

## Requirements
- R1: A synchronous reset loads the counter with RST_CNT and selects the falling run when RST_DOWN is 1, otherwise the rising run. The defaults are 0 and rising, so the index is 0 and the direction flag, hstrobe and sync are all 0.
- R2: In the rising run the counter advances by exactly one per clock until it reaches all ones.
- R3: On reaching all ones while rising, the counter keeps that value for exactly one extra clock (TOP_HOLD). It then loads all-ones minus one and falls.
- R4: In the falling run the counter drops by one per clock down to zero. It keeps zero for one extra clock (BOT_HOLD), then loads 1 and rises.
- R5: After settling, the index, direction flag and sync repeat with a period of 2^(CNT_W+1) clocks, which is 32 clocks by default.
- R6: bit_idx equals the low IDX_W bits of the counter (bits 2..0 by default). The higher bits are not visible on it.
- R7: dir_down is 1 in TOP_HOLD and throughout the falling run, and 0 in BOT_HOLD and throughout the rising run.
- R8: hstrobe goes to 1 in the first clock after each hold state, when the counter has just reloaded, and stays at 1 for exactly STROBE_LEN clocks. It is 0 at all other times.
- R9: sync is 1 exactly in the clocks where the whole counter equals SYNC_STATE (3 by default). This happens once in each run.
- R10: From every reset preset (any count value with either direction), the outputs follow the sequence defined by R2 to R4 and reach the common cycle within 2^(CNT_W+1)+2 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_idx | output | IDX_W | Bit-position index, low bits of the counter |
| dir_down | output | 1 | 1 while the current word is read in descending order |
| hstrobe | output | 1 | Turnaround strobe, STROBE_LEN clocks long |
| sync | output | 1 | High while the counter equals SYNC_STATE |

## Verification
The main instance uses CNT_W=4, IDX_W=3, SYNC_STATE=3 and STROBE_LEN=5. With a 5-clock strobe, any strobe too long or too short is visible well inside the 16-clock half period. Thirty-two further instances keep the default strobe length of 4 and set RST_CNT and RST_DOWN to every pair of count value and direction. This puts convergence from each start state within reach of a reset alone, including the starts that sit on a terminal value in the wrong direction. Random reset pulses cut into every phase of the cycle, and a reference computed in the bench follows all instances clock by clock.

// File: rtl/bstair_pkg.sv
package bstair_pkg;

    // Phases of the bouncing staircase
    typedef enum logic [1:0] {
        PH_RISE     = 2'd0,
        PH_TOP_HOLD = 2'd1,
        PH_FALL     = 2'd2,
        PH_BOT_HOLD = 2'd3
    } bstair_phase_e;

endpackage

// File: rtl/bstair_walker.sv
module bstair_walker
    import bstair_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int RST_CNT  = 0,
    parameter bit RST_DOWN = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [CNT_W-1:0]     cnt_o,
    output bstair_phase_e        phase_o,
    output logic                 hold_o,
    output logic                 term_o
);

    localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_BOT  = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RST_CNT);

    bstair_phase_e    phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= RST_DOWN ? PH_FALL : PH_RISE;
            cnt_q   <= CNT_INIT;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and count
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_RISE: begin
                if (cnt_q == CNT_TOP) phase_d = PH_TOP_HOLD;
                else                  cnt_d   = cnt_q + CNT_ONE;
            end
            PH_TOP_HOLD: begin
                cnt_d   = CNT_TOP - CNT_ONE;
                phase_d = PH_FALL;
            end
            PH_FALL: begin
                if (cnt_q == CNT_BOT) phase_d = PH_BOT_HOLD;
                else                  cnt_d   = cnt_q - CNT_ONE;
            end
            PH_BOT_HOLD: begin
                cnt_d   = CNT_ONE;
                phase_d = PH_RISE;
            end
            default: begin
                cnt_d   = CNT_BOT;
                phase_d = PH_RISE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cnt_o   = cnt_q;
        phase_o = phase_q;
        hold_o  = (phase_q == PH_TOP_HOLD) || (phase_q == PH_BOT_HOLD);
        term_o  = (cnt_q == CNT_TOP) || (cnt_q == CNT_BOT);
    end

    // R2: one step up per clock while rising below the top
    a_r2_rise_step: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RISE && cnt_q != CNT_TOP) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

    // R3: top hold sits at all ones and reloads one below it
    a_r3_top_reload: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TOP_HOLD) |=> (cnt_q == CNT_TOP - CNT_ONE && phase_q == PH_FALL));

    a_r3_top_value: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RISE && cnt_q == CNT_TOP) |=> (phase_q == PH_TOP_HOLD && $stable(cnt_q)));

    // R4: bottom hold reloads one and turns upward
    a_r4_bot_reload: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BOT_HOLD) |=> (cnt_q == CNT_ONE && phase_q == PH_RISE));

endmodule

// File: rtl/bstair_decode.sv
module bstair_decode
    import bstair_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int IDX_W      = 3,
    parameter int SYNC_STATE = 3
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  bstair_phase_e    phase_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             dir_down_o,
    output logic             sync_o
);

    localparam logic [CNT_W-1:0] SYNC_VAL = CNT_W'(SYNC_STATE);

    always_comb begin
        idx_o  = cnt_i[IDX_W-1:0];
        sync_o = (cnt_i == SYNC_VAL);
        unique case (phase_i)
            PH_TOP_HOLD, PH_FALL: dir_down_o = 1'b1;
            default:              dir_down_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bstair_strobe.sv
module bstair_strobe #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  logic term_i,
    output logic strobe_o
);

    logic hold_q;
    logic trig;

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= hold_i;
    end

    // Hold seen last clock and counter already off its terminal value
    assign trig = hold_q & ~term_i;

    generate
        if (LEN <= 1) begin : g_single
            assign strobe_o = trig;
        end else begin : g_stretch
            localparam int REM_W = $clog2(LEN);
            localparam logic [REM_W-1:0] REM_LOAD = REM_W'(LEN - 1);
            logic [REM_W-1:0] rem_q;

            always_ff @(posedge clk) begin
                if (rst)              rem_q <= '0;
                else if (trig)        rem_q <= REM_LOAD;
                else if (rem_q != '0) rem_q <= rem_q - 1'b1;
            end

            assign strobe_o = trig | (rem_q != '0);

            // R8: the stretch never exceeds its loaded length
            a_r8_rem_bound: assert property (@(posedge clk) disable iff (rst)
                (rem_q != '0) |=> (rem_q < $past(rem_q) || trig));
        end
    endgenerate

endmodule

// File: rtl/bounce_stair_gen.sv
module bounce_stair_gen
    import bstair_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int IDX_W      = 3,
    parameter int STROBE_LEN = 4,
    parameter int SYNC_STATE = 3,
    parameter int RST_CNT    = 0,
    parameter bit RST_DOWN   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] bit_idx,
    output logic             dir_down,
    output logic             hstrobe,
    output logic             sync
);

    logic [CNT_W-1:0] cnt;
    bstair_phase_e    phase;
    logic             hold;
    logic             term;

    bstair_walker #(
        .CNT_W   (CNT_W),
        .RST_CNT (RST_CNT),
        .RST_DOWN(RST_DOWN)
    ) u_walker (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt),
        .phase_o(phase),
        .hold_o (hold),
        .term_o (term)
    );

    bstair_decode #(
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W),
        .SYNC_STATE(SYNC_STATE)
    ) u_decode (
        .cnt_i     (cnt),
        .phase_i   (phase),
        .idx_o     (bit_idx),
        .dir_down_o(dir_down),
        .sync_o    (sync)
    );

    bstair_strobe #(
        .LEN(STROBE_LEN)
    ) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .hold_i  (hold),
        .term_i  (term),
        .strobe_o(hstrobe)
    );

    // R7: the direction flag is up in the clock after the top hold
    a_r7_dir_after_top: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TOP_HOLD) |=> dir_down);

    a_r7_dir_after_bot: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BOT_HOLD) |=> !dir_down);

    // R8: every hold is followed by a strobe
    a_r8_strobe_after_hold: assert property (@(posedge clk) disable iff (rst)
        hold |=> hstrobe);

    // R9: sync only when the index shows the sync value's low bits
    a_r9_sync_idx: assert property (@(posedge clk) disable iff (rst)
        sync |-> (bit_idx == IDX_W'(SYNC_STATE)));

endmodule

// File: tb/test_bounce_stair_gen.sv
module test_bounce_stair_gen;

    localparam int NREC  = 32;
    localparam int MAIN  = 32;
    localparam int NCYC  = 900;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    logic [2:0] m_idx;
    logic       m_dir, m_stb, m_sync;

    bounce_stair_gen #(.STROBE_LEN(5)) i_bounce_stair_gen (
        .clk(clk), .rst(rst), .bit_idx(m_idx), .dir_down(m_dir),
        .hstrobe(m_stb), .sync(m_sync)
    );

    logic [2:0] r_idx  [NREC];
    logic       r_dir  [NREC];
    logic       r_stb  [NREC];
    logic       r_sync [NREC];

    for (genvar g = 0; g < NREC; g++) begin : g_rec
        bounce_stair_gen #(
            .RST_CNT (g % 16),
            .RST_DOWN(g >= 16)
        ) i_bounce_stair_gen (
            .clk(clk), .rst(rst), .bit_idx(r_idx[g]), .dir_down(r_dir[g]),
            .hstrobe(r_stb[g]), .sync(r_sync[g])
        );
    end

    // Reference state: phase 0 rise, 1 top hold, 2 fall, 3 bottom hold
    int e_cnt [NREC+1];
    int e_ph  [NREC+1];
    int e_hq  [NREC+1];
    int e_rem [NREC+1];
    int e_len [NREC+1];

    function automatic int f_next_cnt(int c, int ph);
        case (ph)
            0: return (c == 15) ? c : c + 1;
            1: return 14;
            2: return (c == 0) ? c : c - 1;
            default: return 1;
        endcase
    endfunction

    function automatic int f_next_ph(int c, int ph);
        case (ph)
            0: return (c == 15) ? 1 : 0;
            1: return 2;
            2: return (c == 0) ? 3 : 2;
            default: return 0;
        endcase
    endfunction

    function automatic bit f_trig(int k);
        return (e_hq[k] != 0) && !(e_cnt[k] == 15 || e_cnt[k] == 0);
    endfunction

    function automatic bit f_stb(int k);
        return f_trig(k) || (e_rem[k] != 0);
    endfunction

    task automatic reset_model(int k);
        e_cnt[k] = (k == MAIN) ? 0 : (k % 16);
        e_ph[k]  = (k == MAIN) ? 0 : ((k >= 16) ? 2 : 0);
        e_hq[k]  = 0;
        e_rem[k] = 0;
    endtask

    task automatic step_model(int k);
        bit t = f_trig(k);
        int nc = f_next_cnt(e_cnt[k], e_ph[k]);
        int np = f_next_ph(e_cnt[k], e_ph[k]);
        e_hq[k]  = (e_ph[k] == 1 || e_ph[k] == 3) ? 1 : 0;
        e_rem[k] = t ? e_len[k] - 1 : ((e_rem[k] > 0) ? e_rem[k] - 1 : 0);
        e_cnt[k] = nc;
        e_ph[k]  = np;
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int k = MAIN;
        int ei = e_cnt[k] % 8;
        int ed = (e_ph[k] == 1 || e_ph[k] == 2) ? 1 : 0;
        int es = (e_cnt[k] == 3) ? 1 : 0;
        int eb = f_stb(k) ? 1 : 0;
        chk(int'(m_idx) == ei, "R2 R3 R4 R6 bit_idx", int'(m_idx), ei);
        chk(int'(m_dir) == ed, "R7 dir_down", int'(m_dir), ed);
        chk(int'(m_sync) == es, "R9 sync", int'(m_sync), es);
        chk(int'(m_stb) == eb, "R8 hstrobe", int'(m_stb), eb);
        for (int j = 0; j < NREC; j++) begin
            int xi = e_cnt[j] % 8;
            int xd = (e_ph[j] == 1 || e_ph[j] == 2) ? 1 : 0;
            int xs = (e_cnt[j] == 3) ? 1 : 0;
            int xb = f_stb(j) ? 1 : 0;
            chk(int'(r_idx[j]) == xi && int'(r_dir[j]) == xd &&
                int'(r_sync[j]) == xs && int'(r_stb[j]) == xb,
                $sformatf("R10 preset %0d idx/dir/sync/strobe", j),
                {r_idx[j], r_dir[j], r_sync[j], r_stb[j]}, (xi << 3) | (xd << 2) | (xs << 1) | xb);
        end
    endtask

    int hist [NCYC];

    initial begin
        bit rn;
        int rlen;
        void'($urandom(32'd20240611));
        for (int k = 0; k <= NREC; k++) begin
            e_len[k] = (k == MAIN) ? 5 : 4;
            reset_model(k);
        end
        rlen = 0;
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            hist[c] = {m_idx, m_dir, m_sync};
            if (c == 0) begin
                // R1: default reset state
                chk(m_idx == 3'd0 && !m_dir && !m_sync && !m_stb, "R1 reset outputs",
                    {m_idx, m_dir, m_sync, m_stb}, 0);
            end
            compare_all();
            // Reset schedule: two clocks at start, random pulses after cycle 300
            if (c < 1) rn = 1'b1;
            else if (rlen > 0) begin
                rn = 1'b1;
                rlen--;
            end else if (c > 300 && ($urandom % 48) == 0) begin
                rn = 1'b1;
                rlen = $urandom % 3;
            end else rn = 1'b0;
            for (int k = 0; k <= NREC; k++) begin
                if (rn) reset_model(k);
                else    step_model(k);
            end
            rst = rn;
        end
        // R5: the outputs repeat every 32 clocks once running (no resets before 300)
        for (int c = 40; c < 240; c += 13) begin
            chk(hist[c] == hist[c + 32], "R5 period 32", hist[c + 32], hist[c]);
        end
        // R5: a half period apart the direction differs
        chk(hist[50][1] != hist[66][1], "R5 direction flips each half period", hist[66][1], !hist[50][1]);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule